// File: doc/BRIEF.md
# Macroblock SAD Engine

This block scores how well one 16x16 candidate block matches a 16x16 reference macroblock. It computes the sum of absolute differences over all 256 pixel pairs. The two blocks live in separate pixel memories. Each memory returns one packed 24-bit colour pixel one clock after the read. The engine takes the base address of each block and walks both blocks in the same row-major order, one pixel pair per cycle. For each pair it sums the absolute differences of the three 8-bit colour channels and adds that to a running total.

A parent controller sequences the engine through four states: idle/reset, calculating, done and complete. The engine only asks to move on. It raises a request, and it changes state only on a clock edge where the parent acknowledges that request. The total is cleared when a calculation starts. It then stays frozen from the done state until the next calculation starts, so the parent can read it at its own pace. Choosing candidate positions and storing the frames are left to the parent.

Top module: `mb_sad_engine`

## Requirements
- R1: After reset the state is idle (code 0), `req_o` is 1, `done_o` is 0, `rd_en_o` is 0 and `sad_o` is 0.
- R2: State codes are idle=0, calculating=1, done=2, complete=3. The state advances idle→calculating→done→complete→idle, one step per clock edge on which both `ack_i` and `req_o` are 1. Otherwise the state holds.
- R3: An `ack_i` that arrives while `req_o` is 0 has no effect. The engine stays in calculating.
- R4: Each calculation issues exactly 256 reads, asserting `rd_en_o` only in calculating. Read k = 16·r + c addresses base + 96·r + c on each port, where r is the row and c is the column, both 0 to 15, with the column varying fastest.
- R5: The total is 0 in the cycle after the edge that enters calculating. A new result never includes earlier sums.
- R6: The pixel metric is |Δ[23:16]| + |Δ[15:8]| + |Δ[7:0]| over the three 8-bit channels. `sad_o` is the sum of this metric over all 256 pairs.
- R7: `req_o` rises in calculating exactly 257 clock edges after the edge that entered it, so one pair is accumulated per cycle.
- R8: `done_o` is 1 only in the done state. `sad_o` holds its value through done, complete and idle until the next calculation starts.
- R9: The worst case of 256 × 765 = 195840 is reported exactly, with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ack_i | input | 1 | Parent acknowledge of a state change request |
| ref_base_i | input | 14 | Reference block base address, sampled on the edge that enters calculating |
| cand_base_i | input | 14 | Candidate block base address, sampled on the same edge |
| req_o | output | 1 | Engine requests a move to the next state |
| state_o | output | 2 | Current state code |
| ref_addr_o | output | 14 | Reference memory read address |
| cand_addr_o | output | 14 | Candidate memory read address |
| rd_en_o | output | 1 | Read strobe for both memories |
| ref_pix_i | input | 24 | Reference pixel, valid one cycle after the read |
| cand_pix_i | input | 24 | Candidate pixel, valid one cycle after the read |
| sad_o | output | 19 | Sum of absolute differences |
| done_o | output | 1 | High in the done state |

## Verification
Four pixel patterns are used:
- Identical patterns at the same base must give zero. A nonzero result exposes misaligned address streams or an off-by-one pipeline.
- All-zero against all-ones gives the largest possible total and shows whether the accumulator overflows.
- A fixed pair whose channels differ in opposite directions (reference larger in one channel, candidate larger in others) catches a signed or wrapped difference in any channel.
- An address-dependent pattern at two different bases only matches the independently computed total if the row stride and column order are right.

Early acknowledges and idle waits then test that the handshake gates every state change and that the total holds while it waits.

// File: rtl/mb_sad_pkg.sv
package mb_sad_pkg;

   typedef enum logic [1:0] {
      ST_IDLE     = 2'd0,
      ST_CALC     = 2'd1,
      ST_DONE     = 2'd2,
      ST_COMPLETE = 2'd3
   } sad_state_e;

endpackage

// File: rtl/mb_sad_addr_walk.sv
module mb_sad_addr_walk #(
   parameter int FRAME_W = 96,
   parameter int BLK     = 16,
   parameter int ADDR_W  = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] base,
   output logic [ADDR_W-1:0] addr,
   output logic              busy
);
   localparam int POS_W = (BLK > 1) ? $clog2(BLK) : 1;
   localparam logic [ADDR_W-1:0] ROW_JUMP = ADDR_W'(FRAME_W - BLK + 1);
   localparam logic [POS_W-1:0]  LAST_POS = POS_W'(BLK - 1);

   generate
      if (FRAME_W < BLK) begin : g_bad_frame
         $error("mb_sad_addr_walk: FRAME_W must be at least BLK");
      end
   endgenerate

   logic [ADDR_W-1:0] ptr_q;
   logic [POS_W-1:0]  col_q, row_q;
   logic              busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q  <= '0;
         col_q  <= '0;
         row_q  <= '0;
         busy_q <= 1'b0;
      end else if (load) begin
         ptr_q  <= base;
         col_q  <= '0;
         row_q  <= '0;
         busy_q <= 1'b1;
      end else if (busy_q) begin
         if (col_q == LAST_POS) begin
            col_q <= '0;
            ptr_q <= ptr_q + ROW_JUMP;
            if (row_q == LAST_POS) busy_q <= 1'b0;
            else                   row_q  <= row_q + 1'b1;
         end else begin
            col_q <= col_q + 1'b1;
            ptr_q <= ptr_q + 1'b1;
         end
      end
   end

   assign addr = ptr_q;
   assign busy = busy_q;

   AST_WALK_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !load && col_q == LAST_POS && row_q == LAST_POS) |=> !busy_q); // R4
endmodule

// File: rtl/mb_sad_pix_diff.sv
module mb_sad_pix_diff #(
   parameter int CH_W   = 8,
   parameter int NCH    = 3,
   parameter int DIFF_W = $clog2(NCH * ((1 << CH_W) - 1) + 1)
) (
   input  logic [CH_W*NCH-1:0] a,
   input  logic [CH_W*NCH-1:0] b,
   output logic [DIFF_W-1:0]   diff
);
   logic [CH_W-1:0] ch_abs [NCH];

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_ch
         logic [CH_W-1:0] ca, cb;
         assign ca = a[i*CH_W +: CH_W];
         assign cb = b[i*CH_W +: CH_W];
         assign ch_abs[i] = (ca >= cb) ? (ca - cb) : (cb - ca);
      end
   endgenerate

   always_comb begin
      diff = '0;
      for (int i = 0; i < NCH; i++) diff = diff + DIFF_W'(ch_abs[i]);
   end
endmodule

// File: rtl/mb_sad_engine.sv
module mb_sad_engine
   import mb_sad_pkg::*;
#(
   parameter int FRAME_W = 96,
   parameter int BLK     = 16,
   parameter int ADDR_W  = 14,
   parameter int CH_W    = 8,
   parameter int NCH     = 3,
   parameter int SAD_W   = 19
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ack_i,
   input  logic [ADDR_W-1:0]    ref_base_i,
   input  logic [ADDR_W-1:0]    cand_base_i,
   output logic                 req_o,
   output logic [1:0]           state_o,
   output logic [ADDR_W-1:0]    ref_addr_o,
   output logic [ADDR_W-1:0]    cand_addr_o,
   output logic                 rd_en_o,
   input  logic [CH_W*NCH-1:0]  ref_pix_i,
   input  logic [CH_W*NCH-1:0]  cand_pix_i,
   output logic [SAD_W-1:0]     sad_o,
   output logic                 done_o
);
   localparam int NPIX    = BLK * BLK;
   localparam int CNT_W   = $clog2(NPIX + 1);
   localparam int DIFF_W  = $clog2(NCH * ((1 << CH_W) - 1) + 1);
   localparam int NEED_W  = $clog2(NPIX * NCH * ((1 << CH_W) - 1) + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(NPIX);

   generate
      if (SAD_W < NEED_W) begin : g_bad_sad
         $error("mb_sad_engine: SAD_W too narrow for the worst-case total");
      end
      if ((FRAME_W * FRAME_W) > (1 << ADDR_W)) begin : g_bad_addr
         $error("mb_sad_engine: ADDR_W cannot span a square frame");
      end
   endgenerate

   sad_state_e        state_q;
   logic [SAD_W-1:0]  sad_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              vld_q;
   logic              start;
   logic              ref_busy, cand_busy;
   logic [DIFF_W-1:0] pair_diff;

   assign start = (state_q == ST_IDLE) && ack_i;

   mb_sad_addr_walk #(.FRAME_W(FRAME_W), .BLK(BLK), .ADDR_W(ADDR_W)) u_ref_walk (
      .clk(clk), .rst_n(rst_n), .load(start), .base(ref_base_i),
      .addr(ref_addr_o), .busy(ref_busy));

   mb_sad_addr_walk #(.FRAME_W(FRAME_W), .BLK(BLK), .ADDR_W(ADDR_W)) u_cand_walk (
      .clk(clk), .rst_n(rst_n), .load(start), .base(cand_base_i),
      .addr(cand_addr_o), .busy(cand_busy));

   mb_sad_pix_diff #(.CH_W(CH_W), .NCH(NCH), .DIFF_W(DIFF_W)) u_diff (
      .a(ref_pix_i), .b(cand_pix_i), .diff(pair_diff));

   assign rd_en_o = ref_busy & cand_busy;
   assign req_o   = (state_q != ST_CALC) || (cnt_q == CNT_FULL);
   assign state_o = state_q;
   assign sad_o   = sad_q;
   assign done_o  = (state_q == ST_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         sad_q   <= '0;
         cnt_q   <= '0;
         vld_q   <= 1'b0;
      end else begin
         vld_q <= rd_en_o;
         unique case (state_q)
            ST_IDLE: if (ack_i) begin
               state_q <= ST_CALC;
               sad_q   <= '0;
               cnt_q   <= '0;
            end
            ST_CALC: begin
               if (vld_q) begin
                  sad_q <= sad_q + SAD_W'(pair_diff);
                  cnt_q <= cnt_q + 1'b1;
               end
               if (ack_i && cnt_q == CNT_FULL) state_q <= ST_DONE;
            end
            ST_DONE:     if (ack_i) state_q <= ST_COMPLETE;
            ST_COMPLETE: if (ack_i) state_q <= ST_IDLE;
            default:     state_q <= ST_IDLE;
         endcase
      end
   end

   AST_HOLD_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_i |=> $stable(state_o)); // R2
   AST_IGNORE_EARLY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      !req_o |=> (state_o == 2'd1)); // R3
   AST_READ_IN_CALC: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en_o |-> (state_o == 2'd1)); // R4
   AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd0 && ack_i) |=> (sad_o == '0)); // R5
   AST_NO_OVERCOUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == CNT_FULL) |-> !vld_q); // R9
   AST_RESULT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd2 || state_o == 2'd3) |=> $stable(sad_o)); // R8
endmodule

// File: tb/mb_sad_engine_bench.sv
module mb_sad_engine_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ack_i = 1'b0;
   logic [13:0] ref_base_i = '0, cand_base_i = '0;
   logic        req_o, rd_en_o, done_o;
   logic [1:0]  state_o;
   logic [13:0] ref_addr_o, cand_addr_o;
   logic [23:0] ref_pix_i = '0, cand_pix_i = '0;
   logic [18:0] sad_o;

   int checks = 0, failures = 0;
   int mode = 0;
   int rd_count = 0, addr_bad = 0;
   logic [13:0] cur_ref_base = '0, cur_cand_base = '0;

   always #2 clk = ~clk;

   mb_sad_engine u_mb_sad_engine (
      .clk(clk), .rst_n(rst_n), .ack_i(ack_i),
      .ref_base_i(ref_base_i), .cand_base_i(cand_base_i),
      .req_o(req_o), .state_o(state_o),
      .ref_addr_o(ref_addr_o), .cand_addr_o(cand_addr_o), .rd_en_o(rd_en_o),
      .ref_pix_i(ref_pix_i), .cand_pix_i(cand_pix_i),
      .sad_o(sad_o), .done_o(done_o));

   function automatic logic [23:0] pat_ref(input logic [13:0] a);
      case (mode)
         0: return {a[7:0], a[13:6], a[7:0] ^ 8'h5A};
         1: return 24'h000000;
         2: return 24'h108000;
         default: return {a[7:0] * 8'd3, a[7:0] ^ a[13:6], a[7:0] + 8'd17};
      endcase
   endfunction

   function automatic logic [23:0] pat_cand(input logic [13:0] a);
      case (mode)
         0: return {a[7:0], a[13:6], a[7:0] ^ 8'h5A};
         1: return 24'hFFFFFF;
         2: return 24'h2000FF;
         default: return {a[7:0] * 8'd5, ~a[7:0], a[12:5]};
      endcase
   endfunction

   function automatic int ch_abs(input logic [7:0] x, input logic [7:0] y);
      return (x >= y) ? int'(x - y) : int'(y - x);
   endfunction

   function automatic int expect_sad(input logic [13:0] rb, input logic [13:0] cb);
      int s = 0;
      for (int r = 0; r < 16; r++) begin
         for (int c = 0; c < 16; c++) begin
            logic [23:0] p = pat_ref(rb + 14'(r * 96 + c));
            logic [23:0] q = pat_cand(cb + 14'(r * 96 + c));
            s += ch_abs(p[23:16], q[23:16]) + ch_abs(p[15:8], q[15:8]) + ch_abs(p[7:0], q[7:0]);
         end
      end
      return s;
   endfunction

   // memory models with one-cycle read latency, plus an address order monitor
   always @(posedge clk) begin
      if (rd_en_o) begin
         if (ref_addr_o  != cur_ref_base  + 14'((rd_count / 16) * 96 + rd_count % 16) ||
             cand_addr_o != cur_cand_base + 14'((rd_count / 16) * 96 + rd_count % 16))
            addr_bad++;
         rd_count++;
         ref_pix_i  <= pat_ref(ref_addr_o);
         cand_pix_i <= pat_cand(cand_addr_o);
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic pulse_ack();
      ack_i = 1'b1;
      @(negedge clk);
      ack_i = 1'b0;
   endtask

   task automatic test_reset();
      @(negedge clk);
      check("R1 state", state_o, 0);
      check("R1 req", req_o, 1);
      check("R1 done", done_o, 0);
      check("R1 rd_en", rd_en_o, 0);
      check("R1 sad", sad_o, 0);
      repeat (3) @(negedge clk);
      check("R2 idle holds without ack", state_o, 0);
   endtask

   task automatic run_eval(input string name, input int m, input logic [13:0] rb,
                           input logic [13:0] cb, input bit early_ack);
      int n = 0;
      int exp;
      int held;
      mode = m;
      exp = expect_sad(rb, cb);
      ref_base_i = rb; cand_base_i = cb;
      cur_ref_base = rb; cur_cand_base = cb;
      rd_count = 0; addr_bad = 0;
      pulse_ack();
      check({name, " R2 entered calc"}, state_o, 1);
      check({name, " R5 cleared on start"}, sad_o, 0);
      ref_base_i = ~rb; cand_base_i = ~cb;
      while (!req_o && n < 400) begin
         ack_i = early_ack && (n < 10);
         @(negedge clk);
         n++;
         if (early_ack && n == 10) check({name, " R3 early ack ignored"}, state_o, 1);
      end
      ack_i = 1'b0;
      check({name, " R7 cycles to result"}, n, 257);
      check({name, " R6 sad value"}, sad_o, exp);
      check({name, " R4 read count"}, rd_count, 256);
      check({name, " R4 address order"}, addr_bad, 0);
      check({name, " R4 reads stopped"}, rd_en_o, 0);
      pulse_ack();
      check({name, " R2 done state"}, state_o, 2);
      check({name, " R8 done flag"}, done_o, 1);
      held = sad_o;
      repeat (6) @(negedge clk);
      check({name, " R8 sad held in done"}, sad_o, held);
      pulse_ack();
      check({name, " R2 complete state"}, state_o, 3);
      check({name, " R8 done low"}, done_o, 0);
      pulse_ack();
      check({name, " R2 back to idle"}, state_o, 0);
      check({name, " R8 sad held in idle"}, sad_o, exp);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      test_reset();
      run_eval("same", 0, 14'd1000, 14'd1000, 1'b0);           // R6 zero case
      run_eval("max", 1, 14'd0, 14'd5000, 1'b0);               // R9
      check("R9 worst case total", sad_o, 195840);
      run_eval("chan", 2, 14'd200, 14'd300, 1'b1);             // R3, R6 channels
      check("R6 channel directions", sad_o, 102144);
      run_eval("stride", 3, 14'd97, 14'd96 * 14'd20 + 14'd30, 1'b0); // R4, R5 reuse
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule